// File: doc/BRIEF.md
# Configurable Logic Macrocell with Input-Register Option

The block is one output cell of a programmable-logic fabric. Its data input is a sum-term from the product-term allocator. A configuration bit can invert that sum-term. The result then passes through a storage element, and four modes are available for it: combinational bypass, D flip-flop, T flip-flop, or level-sensitive latch. The storage element is timed by one of two global clocks, chosen by a select bit. The two global clocks are sampled on the fabric clock `clk`. A rising edge of the chosen global clock is detected between two `clk` samples. Its high level serves as the latch enable.

The cell's value always goes back to the routing matrix on a feedback output, whatever the pin is doing. The pin driver is active only while the output-enable is high. While it is low, the pin's input value is forwarded to the neighbouring cell's input-register path. When the cell is configured as buried, it takes its data from the neighbouring pin instead of the sum-term. In that case it acts as a D-type input register or an input latch, and it never drives its own pin.

The stored bit is a two-state machine with states `BIT_LO` and `BIT_HI`:
- Asynchronous clear goes to `BIT_LO`.
- Asynchronous set goes to `BIT_HI`.
- A capture (D edge, or latch enable high) goes to the state matching the data.
- A toggle (T edge with data 1) goes to the opposite state.
- In every other case the state holds.

Top module: `mc_cell`

## Requirements
- R1: With `cfg_mode`=0 (combinational) and `cfg_buried`=0, `fb_o` equals `sum_term` XOR `cfg_invert` in the same cycle.
- R2: With `cfg_mode`=1 (D), the stored bit takes the polarity-adjusted input at a `clk` edge where the selected global clock was low at the previous edge and is high now. At all other times it holds.
- R3: With `cfg_mode`=2 (T), a detected rising edge of the selected global clock inverts the stored bit when the polarity-adjusted input is 1. It holds the bit when that input is 0.
- R4: With `cfg_mode`=3 (latch), the output follows the polarity-adjusted input while the selected global clock is high. When that clock goes low, the output holds the value captured at the last `clk` edge seen while the clock was high.
- R5: `cfg_clk_sel` chooses which bit of `gclk` acts as the clock or enable. Activity on the other bit has no effect on the output.
- R6: `async_rst` forces the output to 0 at once in every registered mode (1, 2 or 3), and in buried mode. This happens without any clock and takes priority over `async_pre`.
- R7: `async_pre` with `async_rst` low forces the output to 1 at once in every registered mode and in buried mode.
- R8: `pin_oe_o` is high exactly when `oe` is high and `cfg_buried` is 0. While it is high, `pin_o` equals `fb_o`; otherwise `pin_o` is 0.
- R9: `pin_fwd_o` equals `pin_i` while the pin is not driven, and is 0 while it is driven.
- R10: With `cfg_buried`=1, the data source is `nbr_pin` and `sum_term` and `cfg_invert` have no effect. The cell behaves as a D register when `cfg_in_latch`=0 and as a latch when `cfg_in_latch`=1, regardless of `cfg_mode`.
- R11: `fb_o` carries the cell's value in every configuration, independent of `oe` and `pin_i`.
- R12: While `rst_n` is low, the stored bit and the edge detectors are cleared, so every registered mode outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric sampling clock |
| rst_n | input | 1 | Active-low reset of the stored bit and edge detectors |
| cfg_mode | input | 2 | Storage mode: 0 combinational, 1 D, 2 T, 3 latch |
| cfg_invert | input | 1 | Invert the sum-term when 1 |
| cfg_clk_sel | input | SEL_W (1) | Index of the global clock used |
| cfg_buried | input | 1 | Buried input-register configuration |
| cfg_in_latch | input | 1 | In buried mode: 1 latch, 0 D register |
| sum_term | input | 1 | Sum-term from the product-term allocator |
| gclk | input | NUM_GCLK (2) | Global clock levels |
| async_rst | input | 1 | Asynchronous clear, active high |
| async_pre | input | 1 | Asynchronous set, active high |
| oe | input | 1 | Pin output-enable |
| pin_i | input | 1 | Value seen on this cell's pin |
| nbr_pin | input | 1 | Value seen on the neighbouring cell's pin |
| fb_o | output | 1 | Feedback to the routing matrix |
| pin_o | output | 1 | Pin drive value |
| pin_oe_o | output | 1 | Pin driver enable |
| pin_fwd_o | output | 1 | Pin input forwarded to the neighbour's input register |

## Verification
The assertions assume the following about the inputs:
- They change only away from the `clk` edge.
- Each asynchronous clear or set pulse stays high across at least one `clk` edge.
- The global clocks are slow against `clk`, so every high and every low phase spans at least one edge.

The stimulus meets these assumptions in three ways. It drives every input just after a falling edge of `clk`. It holds each asynchronous pulse and each clock phase for whole cycles. It changes configuration only between phases, and the toggle assertion tolerates such a change explicitly.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
    typedef enum logic [1:0] {
        SM_COMB  = 2'd0,
        SM_DFF   = 2'd1,
        SM_TFF   = 2'd2,
        SM_LATCH = 2'd3
    } store_mode_e;

    typedef enum logic {
        BIT_LO = 1'b0,
        BIT_HI = 1'b1
    } bit_state_e;
endpackage

// File: rtl/mc_data_sel.sv
`timescale 1ns/1ps
module mc_data_sel
    import mc_pkg::*;
(
    input  logic        sum_term,
    input  logic        invert,
    input  logic        buried,
    input  logic        in_latch,
    input  logic        nbr_pin,
    input  logic [1:0]  mode_raw,
    output logic        d_out,
    output store_mode_e eff_mode
);
    always_comb begin
        if (buried) begin
            d_out    = nbr_pin;
            eff_mode = in_latch ? SM_LATCH : SM_DFF;
        end else begin
            d_out    = sum_term ^ invert;
            eff_mode = store_mode_e'(mode_raw);
        end
    end
endmodule

// File: rtl/mc_clk_pick.sv
`timescale 1ns/1ps
module mc_clk_pick #(
    parameter int NUM_GCLK = 2,
    parameter int SEL_W    = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic [SEL_W-1:0]    sel,
    output logic                sel_level,
    output logic                sel_rise
);
    logic [NUM_GCLK-1:0] prev_q;
    logic [NUM_GCLK-1:0] rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= gclk;
    end

    for (genvar g = 0; g < NUM_GCLK; g++) begin : g_edge
        assign rise[g] = gclk[g] & ~prev_q[g];
    end

    assign sel_level = gclk[sel];
    assign sel_rise  = rise[sel];
endmodule

// File: rtl/mc_store.sv
`timescale 1ns/1ps
module mc_store
    import mc_pkg::*;
(
    input  logic        clk,
    input  logic        clr,
    input  logic        set,
    input  store_mode_e mode,
    input  logic        d,
    input  logic        en_level,
    input  logic        en_rise,
    output logic        q_out
);
    bit_state_e st, st_nxt;

    // state register
    always_ff @(posedge clk or posedge clr or posedge set) begin
        if (clr)      st <= BIT_LO;
        else if (set) st <= BIT_HI;
        else          st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (mode)
            SM_COMB:  st_nxt = st;
            SM_DFF:   if (en_rise) st_nxt = d ? BIT_HI : BIT_LO;
            SM_TFF:   if (en_rise && d) st_nxt = (st == BIT_HI) ? BIT_LO : BIT_HI;
            SM_LATCH: if (en_level) st_nxt = d ? BIT_HI : BIT_LO;
        endcase
    end

    // output
    always_comb begin
        unique case (mode)
            SM_COMB: q_out = d;
            SM_DFF, SM_TFF, SM_LATCH: begin
                if (clr)                             q_out = 1'b0;
                else if (set)                        q_out = 1'b1;
                else if (mode == SM_LATCH && en_level) q_out = d;
                else                                 q_out = (st == BIT_HI);
            end
        endcase
    end
endmodule

// File: rtl/mc_pin_io.sv
`timescale 1ns/1ps
module mc_pin_io (
    input  logic value,
    input  logic oe,
    input  logic buried,
    input  logic pin_i,
    output logic pin_o,
    output logic pin_oe_o,
    output logic pin_fwd_o
);
    logic drive;
    assign drive     = oe & ~buried;
    assign pin_oe_o  = drive;
    assign pin_o     = drive ? value : 1'b0;
    assign pin_fwd_o = drive ? 1'b0 : pin_i;
endmodule

// File: rtl/mc_cell.sv
`timescale 1ns/1ps
module mc_cell
    import mc_pkg::*;
#(
    parameter int NUM_GCLK = 2,
    parameter int SEL_W    = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_mode,
    input  logic                cfg_invert,
    input  logic [SEL_W-1:0]    cfg_clk_sel,
    input  logic                cfg_buried,
    input  logic                cfg_in_latch,
    input  logic                sum_term,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                async_rst,
    input  logic                async_pre,
    input  logic                oe,
    input  logic                pin_i,
    input  logic                nbr_pin,
    output logic                fb_o,
    output logic                pin_o,
    output logic                pin_oe_o,
    output logic                pin_fwd_o
);
    logic        d_sel;
    store_mode_e mode_eff;
    logic        en_level, en_rise;
    logic        clr_all;
    logic        cell_val;

    assign clr_all = async_rst | ~rst_n;

    mc_data_sel u_dsel (
        .sum_term (sum_term),
        .invert   (cfg_invert),
        .buried   (cfg_buried),
        .in_latch (cfg_in_latch),
        .nbr_pin  (nbr_pin),
        .mode_raw (cfg_mode),
        .d_out    (d_sel),
        .eff_mode (mode_eff)
    );

    mc_clk_pick #(.NUM_GCLK(NUM_GCLK), .SEL_W(SEL_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .gclk      (gclk),
        .sel       (cfg_clk_sel),
        .sel_level (en_level),
        .sel_rise  (en_rise)
    );

    mc_store u_store (
        .clk      (clk),
        .clr      (clr_all),
        .set      (async_pre),
        .mode     (mode_eff),
        .d        (d_sel),
        .en_level (en_level),
        .en_rise  (en_rise),
        .q_out    (cell_val)
    );

    mc_pin_io u_pin (
        .value     (cell_val),
        .oe        (oe),
        .buried    (cfg_buried),
        .pin_i     (pin_i),
        .pin_o     (pin_o),
        .pin_oe_o  (pin_oe_o),
        .pin_fwd_o (pin_fwd_o)
    );

    assign fb_o = cell_val;
endmodule

// File: rtl/mc_cell_chk.sv
`timescale 1ns/1ps
module mc_cell_chk #(
    parameter int NUM_GCLK = 2,
    parameter int SEL_W    = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          cfg_mode,
    input logic                cfg_invert,
    input logic [SEL_W-1:0]    cfg_clk_sel,
    input logic                cfg_buried,
    input logic                cfg_in_latch,
    input logic                sum_term,
    input logic [NUM_GCLK-1:0] gclk,
    input logic                async_rst,
    input logic                async_pre,
    input logic                oe,
    input logic                pin_i,
    input logic                nbr_pin,
    input logic                fb_o,
    input logic                pin_o,
    input logic                pin_oe_o,
    input logic                pin_fwd_o
);
    logic [NUM_GCLK-1:0] seen_q;
    logic                sel_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= gclk;
    end
    assign sel_rise = gclk[cfg_clk_sel] & ~seen_q[cfg_clk_sel];

    // R1
    comb_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0 && !cfg_buried) |-> (fb_o == (sum_term ^ cfg_invert)));

    // R6
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (async_rst && (cfg_buried || cfg_mode != 2'd0)) |-> !fb_o);

    // R7
    preset_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (async_pre && !async_rst && (cfg_buried || cfg_mode != 2'd0)) |-> fb_o);

    // R8
    pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe_o |-> (pin_o == fb_o));

    // R9
    fwd_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe_o |-> (pin_fwd_o == pin_i));

    // R3
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd2 && !cfg_buried && !async_rst && !async_pre && sel_rise
         && (sum_term ^ cfg_invert))
        |=> (async_rst || async_pre || cfg_buried || cfg_mode != $past(cfg_mode)
             || fb_o != $past(fb_o)));
endmodule

bind mc_cell mc_cell_chk #(.NUM_GCLK(NUM_GCLK), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_mc_cell.sv
`timescale 1ns/1ps
module tb_mc_cell;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_mode;
    logic       cfg_invert;
    logic [0:0] cfg_clk_sel;
    logic       cfg_buried, cfg_in_latch;
    logic       sum_term;
    logic [1:0] gclk;
    logic       async_rst, async_pre, oe, pin_i, nbr_pin;
    logic       fb_o, pin_o, pin_oe_o, pin_fwd_o;

    int compared = 0;
    int mismatched = 0;
    int cyc_cnt = 0;
    bit done = 0;
    string tag = "R12";

    int m_q = 0;
    int m_prev[2] = '{0, 0};

    always #2.5 clk = ~clk;

    mc_cell dut (.*);

    function automatic int eff_mode();
        if (cfg_buried) return cfg_in_latch ? 3 : 1;
        return int'(cfg_mode);
    endfunction

    function automatic int d_val();
        if (cfg_buried) return int'(nbr_pin);
        return int'(sum_term ^ cfg_invert);
    endfunction

    function automatic int exp_val();
        int m = eff_mode();
        int en = int'(gclk[cfg_clk_sel]);
        if (m == 0) return d_val();
        if (async_rst || !rst_n) return 0;
        if (async_pre) return 1;
        if (m == 3 && en == 1) return d_val();
        return m_q;
    endfunction

    // behavioural reference state
    always @(posedge clk) begin
        int m, en, rise;
        if (!rst_n) begin
            m_q = 0; m_prev[0] = 0; m_prev[1] = 0;
        end else begin
            m = eff_mode();
            en = int'(gclk[cfg_clk_sel]);
            rise = (en == 1 && m_prev[cfg_clk_sel] == 0) ? 1 : 0;
            if (async_rst) m_q = 0;
            else if (async_pre) m_q = 1;
            else if (m == 1 && rise == 1) m_q = d_val();
            else if (m == 2 && rise == 1 && d_val() == 1) m_q = 1 - m_q;
            else if (m == 3 && en == 1) m_q = d_val();
            m_prev[0] = int'(gclk[0]);
            m_prev[1] = int'(gclk[1]);
        end
    end

    task automatic chk1(string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int e = exp_val();
        int drv = (oe && !cfg_buried) ? 1 : 0;
        chk1("fb_o", int'(fb_o), e);
        chk1("pin_oe_o", int'(pin_oe_o), drv);
        chk1("pin_o", int'(pin_o), drv ? e : 0);
        chk1("pin_fwd_o", int'(pin_fwd_o), drv ? 0 : int'(pin_i));
    endtask

    task automatic go(int n);
        repeat (n) begin
            @(negedge clk);
            #1 compare();
        end
    endtask

    task automatic pulse(int idx);
        gclk[idx] = 1'b1; go(2);
        gclk[idx] = 1'b0; go(2);
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 50000 && !done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_mode = 2'd1; cfg_invert = 0; cfg_clk_sel = 0;
        cfg_buried = 0; cfg_in_latch = 0; sum_term = 1; gclk = 2'b00;
        async_rst = 0; async_pre = 0; oe = 0; pin_i = 0; nbr_pin = 0;
        // R12: reset state, registered output 0 even with active input
        tag = "R12"; go(3);
        rst_n = 1; go(1);

        // R1: combinational polarity
        tag = "R1"; cfg_mode = 2'd0;
        for (int i = 0; i < 4; i++) begin
            sum_term = i[0]; cfg_invert = i[1]; go(2);
        end

        // R2: D flip-flop on gclk0
        tag = "R2"; cfg_mode = 2'd1; cfg_invert = 0;
        sum_term = 1; pulse(0);
        sum_term = 0; go(3);
        pulse(0);
        sum_term = 1; cfg_invert = 1; pulse(0);
        cfg_invert = 0; go(2);
        pulse(0);

        // R5: other clock ignored, then switch select
        tag = "R5"; sum_term = 0; pulse(1); pulse(1);
        cfg_clk_sel = 1; pulse(1);
        sum_term = 1; pulse(0);
        cfg_clk_sel = 0;

        // R3: T flip-flop
        tag = "R3"; cfg_mode = 2'd2; sum_term = 1;
        pulse(0); pulse(0); pulse(0);
        sum_term = 0; pulse(0); pulse(0);
        cfg_invert = 1; pulse(0); cfg_invert = 0;

        // R4: latch transparent then holding
        tag = "R4"; cfg_mode = 2'd3; gclk[0] = 1;
        sum_term = 0; go(2); sum_term = 1; go(2); sum_term = 0; go(1); sum_term = 1; go(1);
        gclk[0] = 0; go(1);
        sum_term = 0; go(3); sum_term = 1; go(1); sum_term = 0; go(2);

        // R7 / R6: preset, both together, reset alone
        tag = "R7"; cfg_mode = 2'd1; async_pre = 1; go(2);
        sum_term = 0; pulse(0);
        tag = "R6"; async_rst = 1; go(2);
        async_pre = 0; go(2);
        cfg_mode = 2'd3; gclk[0] = 1; sum_term = 1; go(2);
        gclk[0] = 0; async_rst = 0; go(2);

        // R8 / R9: pin driver and forwarding
        tag = "R8"; cfg_mode = 2'd1; sum_term = 1; pulse(0);
        oe = 1; pin_i = 1; go(2); pin_i = 0; go(1);
        tag = "R9"; oe = 0; pin_i = 1; go(2); pin_i = 0; go(1);

        // R10: buried input register and latch from neighbour pin
        tag = "R10"; cfg_buried = 1; oe = 1; cfg_in_latch = 0; cfg_mode = 2'd0;
        nbr_pin = 0; sum_term = 1; pulse(0);
        nbr_pin = 1; sum_term = 0; go(2); pulse(0);
        cfg_invert = 1; sum_term = 1; go(2); cfg_invert = 0;
        cfg_in_latch = 1; gclk[0] = 1; nbr_pin = 0; go(2); nbr_pin = 1; go(1);
        gclk[0] = 0; go(1); nbr_pin = 0; go(2);
        cfg_buried = 0; cfg_in_latch = 0;

        // R11: mixed traffic, feedback compared every cycle
        tag = "R11";
        for (int k = 0; k < 400; k++) begin
            if (k % 50 == 0) begin
                cfg_mode = 2'($urandom_range(0, 3));
                cfg_buried = ($urandom_range(0, 3) == 0);
                cfg_in_latch = 1'($urandom_range(0, 1));
                cfg_clk_sel = 1'($urandom_range(0, 1));
                cfg_invert = 1'($urandom_range(0, 1));
            end
            sum_term = 1'($urandom_range(0, 1));
            nbr_pin = 1'($urandom_range(0, 1));
            pin_i = 1'($urandom_range(0, 1));
            oe = 1'($urandom_range(0, 1));
            if (k % 3 == 0) gclk = 2'($urandom_range(0, 3));
            async_rst = ($urandom_range(0, 15) == 0);
            async_pre = ($urandom_range(0, 15) == 0);
            go(1);
        end
        async_rst = 0; async_pre = 0; go(2);

        // R12: reset again clears a set bit
        tag = "R12"; cfg_buried = 0; cfg_mode = 2'd1; async_pre = 1; go(1);
        async_pre = 0; rst_n = 0; go(2); rst_n = 1; go(2);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule